// File: doc/BRIEF.md
# Flash Array Erase/Program Sequencer

This block carries out the commands that modify a flash array once the serial front end has decoded them. It takes a single-cycle command strobe with an operation code, a buffer select and a page address. It then runs the operation for a fixed number of clock cycles while it reports busy. There are four operations. The first programs a page from a buffer after erasing the page first. The second programs a page without an erase. The third erases one page. The fourth erases an aligned group of eight pages. An erase drives every byte it covers to all ones. A program reads the chosen buffer byte by byte and writes each byte into the target page.

The block reaches the array and the two page buffers through plain combinational ports. A byte is read back from the array in the same cycle as its address, so the program-without-erase path can merge the buffer into the old contents. That merge models cells that can only be cleared. An active-low protect input fences off the lowest pages. A command that touches the fenced region while protect is active is dropped as if it had never been issued.

Top module: `fl_seq`

## Requirements
- R1: After reset, `ready_o` is high and `arr_we_o` is low.
- R2: Op code 0 (program with erase) runs two phases. The erase phase lasts ERASE_CYC cycles and writes all ones to every byte of the page. The program phase then lasts PROG_CYC cycles and writes each byte of the selected buffer unmodified into the same page.
- R3: Op code 1 (program without erase) runs PROG_CYC cycles. It writes the bitwise AND of each buffer byte and the current array byte, so no array bit can go from 0 to 1.
- R4: Op code 2 (page erase) runs ERASE_CYC cycles and writes all ones to every byte of the addressed page.
- R5: Op code 3 (block erase) runs BLK_CYC cycles and writes all ones to eight consecutive pages. The first of these pages is the command page with its three low bits forced to zero, so the low three bits of the command page are ignored.
- R6: Inside each phase, writes start in the first busy cycle and issue one byte per cycle. Bytes go in ascending order, and page by page for a block erase. No write occurs while `ready_o` is high.
- R7: While `wp_ni` is low, a command whose page (for a block erase, whose base page) is below PROT_PAGES is rejected. A rejected command produces no array write, and `ready_o` stays high.
- R8: While `wp_ni` is high, pages below PROT_PAGES are erased and programmed normally.
- R9: `ready_o` goes low in the cycle after an accepted command. It stays low for exactly the total duration of the operation and then returns high. A command strobed while `ready_o` is low is ignored.
- R10: `cmd_buf_i` selects the buffer. Value 0 reads buffer 0 and value 1 reads buffer 1. The selection appears on `buf_sel_o` during the program phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 2 | Operation code (0..3, see R2 to R5) |
| cmd_buf_i | input | 1 | Buffer select |
| cmd_page_i | input | PAGE_W | Target page, or any page in the target block |
| wp_ni | input | 1 | Protect enable for low pages, active low |
| arr_we_o | output | 1 | Array byte write enable |
| arr_addr_o | output | PAGE_W+log2(PAGE_BYTES) | Array byte address {page, byte} |
| arr_wdata_o | output | DATA_W | Array write data |
| arr_rdata_i | input | DATA_W | Array read data at `arr_addr_o`, same cycle |
| buf_sel_o | output | 1 | Buffer being read |
| buf_addr_o | output | log2(PAGE_BYTES) | Buffer byte address |
| buf_rdata_i | input | DATA_W | Buffer read data, same cycle |
| ready_o | output | 1 | High when idle, low while an operation runs |

## Verification
The bound checker checks several properties on every cycle. A write never happens while the block is idle. Program data never sets a bit that the array had cleared. Write addresses climb by one within a page. A protected command or an idle cycle with no strobe leaves `ready_o` high. Every fall of `ready_o` follows a strobe. The bench scenarios are needed to show the exact busy lengths for each operation. They also show the final page contents after erase, merge and two-phase program, the base alignment of a block erase, the effect of the protect input on either side of the fence, and that a command sent mid-operation leaves its target untouched.

// File: rtl/fl_seq_pkg.sv
package fl_seq_pkg;
  typedef enum logic [1:0] {
    OP_PGM_ERASE = 2'd0,
    OP_PGM       = 2'd1,
    OP_PG_ERASE  = 2'd2,
    OP_BLK_ERASE = 2'd3
  } fl_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_PROG  = 2'd2,
    ST_BLK   = 2'd3
  } fl_st_e;

  localparam int unsigned BLK_PAGES_LOG2 = 3;
endpackage

// File: rtl/fl_prot.sv
module fl_prot #(
  parameter int unsigned PAGE_W     = 13,
  parameter int unsigned PROT_PAGES = 256
) (
  input  logic              wp_ni,
  input  logic [1:0]        op_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              allow_o
);
  import fl_seq_pkg::*;

  logic [PAGE_W-1:0] base;

  always_comb begin
    base = page_i;
    if (fl_op_e'(op_i) == OP_BLK_ERASE) base[BLK_PAGES_LOG2-1:0] = '0;
  end

  generate
    if (PROT_PAGES == 0) begin : g_noprot
      assign allow_o = 1'b1;
    end else begin : g_prot
      assign allow_o = wp_ni || (base >= PAGE_W'(PROT_PAGES));
    end
  endgenerate
endmodule

// File: rtl/fl_ctrl.sv
module fl_ctrl #(
  parameter int unsigned PAGE_W    = 13,
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned ERASE_CYC = 1024,
  parameter int unsigned PROG_CYC  = 2048,
  parameter int unsigned BLK_CYC   = 8192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_buf_i,
  input  logic [PAGE_W-1:0] cmd_page_i,
  input  logic              allow_i,
  output fl_seq_pkg::fl_st_e state_o,
  output logic [CNT_W-1:0]  cnt_o,
  output fl_seq_pkg::fl_op_e op_o,
  output logic              buf_o,
  output logic [PAGE_W-1:0] page_o
);
  import fl_seq_pkg::*;

  localparam logic [CNT_W-1:0] LAST_E = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_P = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_B = CNT_W'(BLK_CYC - 1);

  fl_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic accept;

  assign accept = cmd_valid_i && (st_q == ST_IDLE) && allow_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (accept) begin
          unique case (fl_op_e'(cmd_op_i))
            OP_PGM:       st_d = ST_PROG;
            OP_BLK_ERASE: st_d = ST_BLK;
            default:      st_d = ST_ERASE;
          endcase
        end
      end
      ST_ERASE: if (cnt_q == LAST_E) begin
        cnt_d = '0;
        st_d  = (op_o == OP_PGM_ERASE) ? ST_PROG : ST_IDLE;
      end
      ST_PROG: if (cnt_q == LAST_P) begin
        cnt_d = '0;
        st_d  = ST_IDLE;
      end
      ST_BLK: if (cnt_q == LAST_B) begin
        cnt_d = '0;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      op_o   <= OP_PGM_ERASE;
      buf_o  <= 1'b0;
      page_o <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (accept) begin
        op_o   <= fl_op_e'(cmd_op_i);
        buf_o  <= cmd_buf_i;
        page_o <= cmd_page_i;
      end
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/fl_dp.sv
module fl_dp #(
  parameter int unsigned PAGE_W     = 13,
  parameter int unsigned PAGE_BYTES = 512,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CNT_W      = 14,
  parameter int unsigned BYTE_W     = 9
) (
  input  fl_seq_pkg::fl_st_e      state_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  fl_seq_pkg::fl_op_e      op_i,
  input  logic                    buf_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [DATA_W-1:0]       arr_rdata_i,
  input  logic [DATA_W-1:0]       buf_rdata_i,
  output logic                    arr_we_o,
  output logic [PAGE_W+BYTE_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0]       arr_wdata_o,
  output logic                    buf_sel_o,
  output logic [BYTE_W-1:0]       buf_addr_o
);
  import fl_seq_pkg::*;

  localparam int unsigned BG = BLK_PAGES_LOG2;
  localparam logic [CNT_W-1:0] PG_END  = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] BLK_END = CNT_W'(PAGE_BYTES << BG);

  logic [PAGE_W-1:0] pg;
  logic [BYTE_W-1:0] byte_idx;

  assign byte_idx = cnt_i[BYTE_W-1:0];

  always_comb begin
    pg = page_i;
    if (state_i == ST_BLK) pg[BG-1:0] = cnt_i[BYTE_W+BG-1:BYTE_W];
  end

  always_comb begin
    unique case (state_i)
      ST_ERASE, ST_PROG: arr_we_o = cnt_i < PG_END;
      ST_BLK:            arr_we_o = cnt_i < BLK_END;
      default:           arr_we_o = 1'b0;
    endcase
  end

  always_comb begin
    if (state_i != ST_PROG)    arr_wdata_o = '1;
    else if (op_i == OP_PGM)   arr_wdata_o = buf_rdata_i & arr_rdata_i; // cells only clear
    else                       arr_wdata_o = buf_rdata_i;
  end

  assign arr_addr_o = {pg, byte_idx};
  assign buf_sel_o  = buf_i;
  assign buf_addr_o = byte_idx;
endmodule

// File: rtl/fl_seq.sv
module fl_seq #(
  parameter int unsigned PAGE_W     = 13,
  parameter int unsigned PAGE_BYTES = 512,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PROT_PAGES = 256,
  parameter int unsigned ERASE_CYC  = 1024,
  parameter int unsigned PROG_CYC   = 2048,
  parameter int unsigned BLK_CYC    = 8192,
  localparam int unsigned BYTE_W    = $clog2(PAGE_BYTES),
  localparam int unsigned ADDR_W    = PAGE_W + BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_buf_i,
  input  logic [PAGE_W-1:0] cmd_page_i,
  input  logic              wp_ni,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              buf_sel_o,
  output logic [BYTE_W-1:0] buf_addr_o,
  input  logic [DATA_W-1:0] buf_rdata_i,
  output logic              ready_o
);
  import fl_seq_pkg::*;

  localparam int unsigned MAX_EP  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int unsigned MAX_CYC = (MAX_EP > BLK_CYC) ? MAX_EP : BLK_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic              allow;
  fl_st_e            st;
  logic [CNT_W-1:0]  cnt;
  fl_op_e            op_q;
  logic              buf_q;
  logic [PAGE_W-1:0] page_q;

  fl_prot #(.PAGE_W(PAGE_W), .PROT_PAGES(PROT_PAGES)) u_prot (
    .wp_ni  (wp_ni),
    .op_i   (cmd_op_i),
    .page_i (cmd_page_i),
    .allow_o(allow)
  );

  fl_ctrl #(
    .PAGE_W(PAGE_W), .CNT_W(CNT_W),
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .BLK_CYC(BLK_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_op_i),
    .cmd_buf_i  (cmd_buf_i),
    .cmd_page_i (cmd_page_i),
    .allow_i    (allow),
    .state_o    (st),
    .cnt_o      (cnt),
    .op_o       (op_q),
    .buf_o      (buf_q),
    .page_o     (page_q)
  );

  fl_dp #(
    .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .state_i    (st),
    .cnt_i      (cnt),
    .op_i       (op_q),
    .buf_i      (buf_q),
    .page_i     (page_q),
    .arr_rdata_i(arr_rdata_i),
    .buf_rdata_i(buf_rdata_i),
    .arr_we_o   (arr_we_o),
    .arr_addr_o (arr_addr_o),
    .arr_wdata_o(arr_wdata_o),
    .buf_sel_o  (buf_sel_o),
    .buf_addr_o (buf_addr_o)
  );

  assign ready_o = (st == ST_IDLE);
endmodule

// File: rtl/fl_seq_chk.sv
module fl_seq_chk #(
  parameter int unsigned PAGE_W     = 13,
  parameter int unsigned PAGE_BYTES = 512,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PROT_PAGES = 256,
  localparam int unsigned BYTE_W    = $clog2(PAGE_BYTES),
  localparam int unsigned ADDR_W    = PAGE_W + BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic [PAGE_W-1:0] cmd_page_i,
  input logic              wp_ni,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic [DATA_W-1:0] arr_wdata_o,
  input logic [DATA_W-1:0] arr_rdata_i,
  input logic              ready_o
);
  logic [PAGE_W-1:0] base;
  always_comb begin
    base = cmd_page_i;
    if (cmd_op_i == 2'd3) base[2:0] = '0;
  end

  a_r6_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> !ready_o);

  a_r3_bits_only_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_o && arr_wdata_o != '1) |-> ((arr_wdata_o & ~arr_rdata_i) == '0));

  a_r6_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_o && $past(arr_we_o) && arr_addr_o[BYTE_W-1:0] != '0)
      |-> (arr_addr_o == $past(arr_addr_o) + 1'b1));

  a_r7_reject_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && ready_o && !wp_ni && base < PAGE_W'(PROT_PAGES)) |=> ready_o);

  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !cmd_valid_i) |=> ready_o);

  a_r9_fall_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(cmd_valid_i));
endmodule

bind fl_seq fl_seq_chk #(
  .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .PROT_PAGES(PROT_PAGES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .cmd_page_i(cmd_page_i), .wp_ni(wp_ni), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
  .arr_wdata_o(arr_wdata_o), .arr_rdata_i(arr_rdata_i), .ready_o(ready_o)
);

// File: tb/fl_seq_bench.sv
module fl_seq_bench;
  localparam int CLK_P = 10;
  localparam int PW = 9, PB = 4, BW = 2, DW = 8, PROT = 256;
  localparam int EC = 6, PC = 5, BC = 40;
  localparam int NB = (1 << PW) * PB;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_buf = 0, wp_n = 1;
  logic [1:0] cmd_op = 0;
  logic [PW-1:0] cmd_page = 0;
  logic we, bsel, ready;
  logic [PW+BW-1:0] addr;
  logic [DW-1:0] wdata, rdata, brdata;
  logic [BW-1:0] baddr;

  logic [7:0] mem [NB];
  logic [7:0] ref_mem [NB];
  logic [7:0] bufm [2][PB];
  int checks = 0, errors = 0, cyc = 0;

  // model state
  int m_ph = 0, m_cnt = 0, m_op = 0, m_buf = 0, m_page = 0;

  always #(CLK_P/2) clk = ~clk;

  fl_seq #(.PAGE_W(PW), .PAGE_BYTES(PB), .DATA_W(DW), .PROT_PAGES(PROT),
           .ERASE_CYC(EC), .PROG_CYC(PC), .BLK_CYC(BC)) u_fl_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_buf_i(cmd_buf), .cmd_page_i(cmd_page), .wp_ni(wp_n),
    .arr_we_o(we), .arr_addr_o(addr), .arr_wdata_o(wdata), .arr_rdata_i(rdata),
    .buf_sel_o(bsel), .buf_addr_o(baddr), .buf_rdata_i(brdata), .ready_o(ready));

  assign rdata  = mem[addr];
  assign brdata = bufm[bsel][baddr];

  always @(posedge clk) if (we) mem[addr] <= wdata;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle reference compare, then advance model to after next edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL R9 watchdog actual=%0d expected=<100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0;
    end else begin
      bit ew; int ea, ed, pg;
      ew = (m_ph == 1 || m_ph == 2) ? (m_cnt < PB) : (m_ph == 3 ? (m_cnt < 8*PB) : 0);
      pg = (m_ph == 3) ? ((m_page & ~7) + m_cnt / PB) : m_page;
      ea = pg * PB + (m_cnt % PB);
      if (m_ph == 2) ed = (m_op == 1) ? (bufm[m_buf][m_cnt % PB] & ref_mem[ea]) : bufm[m_buf][m_cnt % PB];
      else ed = 8'hFF;
      chk("R9 ready", ready, m_ph == 0);
      chk("R6 write enable", we, ew);
      if (ew && we) begin
        chk("R6 write addr", addr, ea);
        chk("R2/R3/R4/R5 write data", wdata, ed);
        ref_mem[ea] = ed[7:0];
      end
      m_cnt++;
      case (m_ph)
        0: begin
          m_cnt = 0;
          if (cmd_valid && (wp_n || cmd_page >= PROT)) begin
            m_op = cmd_op; m_buf = cmd_buf; m_page = cmd_page;
            m_ph = (cmd_op == 1) ? 2 : (cmd_op == 3 ? 3 : 1);
          end
        end
        1: if (m_cnt == EC) begin m_cnt = 0; m_ph = (m_op == 0) ? 2 : 0; end
        2: if (m_cnt == PC) begin m_cnt = 0; m_ph = 0; end
        3: if (m_cnt == BC) begin m_cnt = 0; m_ph = 0; end
        default: m_ph = 0;
      endcase
    end
  end

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  // issue command, return number of busy cycles seen
  task automatic run(input int op, input int bsl, input int page, output int busy);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = 2'(op); cmd_buf = bsl[0]; cmd_page = PW'(page);
    @(posedge clk); #1;
    cmd_valid = 0;
    busy = 0;
    @(negedge clk);
    while (!ready && busy < 1000) begin busy++; @(negedge clk); end
  endtask

  initial begin
    int b;
    for (int i = 0; i < NB; i++) begin mem[i] = init_val(i); ref_mem[i] = init_val(i); end
    bufm[0][0] = 8'h12; bufm[0][1] = 8'h34; bufm[0][2] = 8'h56; bufm[0][3] = 8'h78;
    bufm[1][0] = 8'hF0; bufm[1][1] = 8'h0F; bufm[1][2] = 8'hAA; bufm[1][3] = 8'h5C;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready after reset", ready, 1);
    chk("R1 no write in reset", we, 0);
    rst_n = 1;
    wp_n = 0;

    // R4 page erase, unprotected page while protect active
    run(2, 0, 300, b);
    chk("R4 busy length", b, EC);
    for (int i = 0; i < PB; i++) chk("R4 erased byte", mem[300*PB+i], 8'hFF);

    // R3 + R10 program without erase from buffer 1
    run(1, 1, 301, b);
    chk("R3 busy length", b, PC);
    for (int i = 0; i < PB; i++) chk("R3/R10 merged byte", mem[301*PB+i], bufm[1][i] & init_val(301*PB+i));

    // R2 program with erase from buffer 0
    run(0, 0, 302, b);
    chk("R2 busy length", b, EC + PC);
    for (int i = 0; i < PB; i++) chk("R2/R10 programmed byte", mem[302*PB+i], bufm[0][i]);

    // R5 block erase, low bits of page ignored
    run(3, 0, 315, b);
    chk("R5 busy length", b, BC);
    for (int i = 312*PB; i < 320*PB; i++) chk("R5 block byte", mem[i], 8'hFF);
    chk("R5 page below block untouched", mem[311*PB], init_val(311*PB));
    chk("R5 page above block untouched", mem[320*PB], init_val(320*PB));

    // R7 protected page erase rejected
    run(2, 0, 5, b);
    chk("R7 page reject busy", b, 0);
    for (int i = 0; i < PB; i++) chk("R7 protected page intact", mem[5*PB+i], init_val(5*PB+i));

    // R7 block erase straddling fence: base 248 rejected
    run(3, 0, 255, b);
    chk("R7 block reject busy", b, 0);
    chk("R7 block page intact", mem[255*PB], init_val(255*PB));

    // R8 protect released
    wp_n = 1;
    run(0, 1, 5, b);
    chk("R8 busy length", b, EC + PC);
    for (int i = 0; i < PB; i++) chk("R8 low page programmed", mem[5*PB+i], bufm[1][i]);

    // R9 command while busy is ignored
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = 2; cmd_page = PW'(400);
    @(posedge clk); #1;
    cmd_op = 2; cmd_page = PW'(401);
    @(posedge clk); #1;
    cmd_valid = 0;
    b = 1;
    @(negedge clk);
    while (!ready && b < 1000) begin b++; @(negedge clk); end
    chk("R9 busy length", b, EC);
    chk("R9 first command done", mem[400*PB], 8'hFF);
    chk("R9 busy command ignored", mem[401*PB], init_val(401*PB));

    for (int i = 0; i < NB; i++)
      if (mem[i] != ref_mem[i]) chk("R6 array vs model", mem[i], ref_mem[i]);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule